// File: doc/BRIEF.md
# SDRAM Bank Column Burst Sequencer

This block models, in synthesizable logic, the column side of a single SDRAM bank. It takes decoded bank commands (open, read, write, burst stop, close) together with a start column. It walks a column counter through the selected burst and stores or fetches 16-bit words in an on-chip array of 256 columns. Read words come back after a programmable CAS latency. The two bytes of the output are gated by separate per-byte output enables, which take the place of tri-state pads.

The column counter supports short bursts (1, 2, 4 or 8 columns) that wrap inside their aligned block and end by themselves. It also supports a full-page burst that wraps around all 256 columns with no end of its own. A full-page burst ends only on a burst stop or a close, or when a new read or write replaces it. Two byte-mask inputs act in different ways depending on the direction. On writes they block the array update for their byte in the same cycle. On reads they drop that byte's output enable two cycles later, while the counter keeps running.

The data paths have no valid/ready handshake, because SDRAM timing is fixed. A write word is taken in the cycle it belongs to. A read word is shown in exactly one cycle and cannot be held back. Commands are accepted whenever `cmd_valid` is high.

Top module: `sdram_burst_seq`

## Requirements
- R1: With burst code 4 (full page), a burst from column a touches a, a+1, … a+255 (mod 256) and then a, a+1, … again, one column per cycle, with no end of its own.
- R2: A burst stop (op 4) ends any burst in the cycle it is presented, and the write word presented in that cycle is not stored.
- R3: A read (op 2) or write (op 3) is carried out only while the bank is open. The bank is opened by op 1 from the closed state. A burst stop moves an open bank into a stopped state that only a close (op 5) leaves. A read or write in any other state is ignored, and `seq_violation` is high in the next cycle.
- R4: The word read in the column cycle t appears on `rd_data` with `rd_valid` high in cycle t + `cfg_cas_lat` (1 to 3). The command cycle itself is the first column cycle.
- R5: During a read, `oe_hi` (bits 15:8) and `oe_lo` (bits 7:0) are low exactly when the matching mask was high two cycles before. A byte whose enable is low reads as zero, and neither enable is ever high without `rd_valid`.
- R6: Read masking does not stall the burst. The columns masked on the output are skipped, and the column sequence after them is unchanged.
- R7: Burst codes 0, 1, 2 and 3 select lengths 1, 2, 4 and 8. The column wraps inside the aligned block of that size around the start column, and the burst ends after that many columns.
- R8: A read or write that is accepted during a burst abandons the old burst. The new command's cycle is the first column of the new burst.
- R9: On a write cycle, a high `dqm_hi` or `dqm_lo` leaves that byte of the addressed column unchanged in the same cycle.
- R10: After reset the bank is closed, and `rd_valid`, `rd_data`, `oe_hi`, `oe_lo` and `seq_violation` are all zero.
- R11: A close (op 5) ends any burst in its own cycle. A write word presented then, or after it, is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | 0 none, 1 open, 2 read, 3 write, 4 burst stop, 5 close |
| cmd_col | input | 8 | Start column of a read or write |
| cfg_burst | input | 3 | Burst code, sampled with each read/write: 0..3 short, 4 full page |
| cfg_cas_lat | input | 2 | Read latency in cycles, 1 to 3 |
| wr_data | input | 16 | Write word for the current column cycle |
| dqm_hi | input | 1 | Upper-byte mask |
| dqm_lo | input | 1 | Lower-byte mask |
| rd_data | output | 16 | Read word, with disabled bytes forced to zero |
| rd_valid | output | 1 | A read word is due this cycle |
| oe_hi | output | 1 | Upper-byte output enable |
| oe_lo | output | 1 | Lower-byte output enable |
| seq_violation | output | 1 | One-cycle pulse after an ignored read/write |

## Verification
The assertions assume that `cfg_cas_lat` does not change while read words are still in flight. They also assume that the mask inputs are driven to known levels from reset onwards, since the two-cycle mask delay has no reset and simply follows the pins. The bench changes the latency only after idle cycles have drained the read pipeline, and it holds both masks low while reset is applied. Random command streams are free to break the open/stop/close ordering, because that case is defined behaviour with its own flag.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_BST = 3'd4,
    OP_PRE = 3'd5
  } sbs_op_e;

  typedef enum logic [1:0] {
    BANK_IDLE    = 2'd0,
    BANK_OPEN    = 2'd1,
    BANK_STOPPED = 2'd2
  } bank_t;

  // Burst length in columns for a code; zero means full page.
  function automatic int unsigned burst_span(logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
  import sbs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic [AW-1:0] start_col,
  input  logic [2:0]    bl_code,
  input  logic          stop,
  output logic          acc_en,
  output logic          acc_wr,
  output logic [AW-1:0] acc_col
);
  logic          act_q, wr_q, full_q;
  logic [AW-1:0] base_q, k_q, mask_q;
  logic [AW-1:0] new_mask;
  logic          new_full;

  always_comb begin
    new_full = (burst_span(bl_code) == 0);
    new_mask = new_full ? '1 : AW'(burst_span(bl_code) - 1);
  end

  // Column touched in this cycle
  always_comb begin
    acc_en  = 1'b0;
    acc_wr  = 1'b0;
    acc_col = start_col;
    if (start) begin
      acc_en = 1'b1;
      acc_wr = start_wr;
    end else if (!stop && act_q) begin
      acc_en  = 1'b1;
      acc_wr  = wr_q;
      acc_col = (base_q & ~mask_q) | ((base_q + k_q) & mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      full_q <= 1'b0;
      base_q <= '0;
      k_q    <= '0;
      mask_q <= '0;
    end else if (start) begin
      act_q  <= new_full || (new_mask != '0);
      wr_q   <= start_wr;
      base_q <= start_col;
      mask_q <= new_mask;
      full_q <= new_full;
      k_q    <= AW'(1);
    end else if (stop) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      k_q <= k_q + AW'(1);
      if (!full_q && k_q == mask_q) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we_hi,
  input  logic          we_lo,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = DW / 2;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_hi) mem_q[addr][DW-1:BW] <= wdata[DW-1:BW];
    if (we_lo) mem_q[addr][BW-1:0]  <= wdata[BW-1:0];
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
  parameter int DW     = 16,
  parameter int MAX_CL = 3,
  parameter int QMD    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch,
  input  logic [DW-1:0] fetch_data,
  input  logic [1:0]    cas_lat,
  input  logic          mask_hi,
  input  logic          mask_lo,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          oe_hi,
  output logic          oe_lo
);
  localparam int BW = DW / 2;

  logic [MAX_CL-1:0] v_q;
  logic [DW-1:0]     d_q [MAX_CL];
  logic [QMD-1:0]    mh_q, ml_q;
  int                sel;

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= '0;
    else begin
      v_q[0] <= fetch;
      for (int i = 1; i < MAX_CL; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    d_q[0] <= fetch_data;
    for (int i = 1; i < MAX_CL; i++) d_q[i] <= d_q[i-1];
  end

  // Mask delay line: follows the pins, no reset needed
  always_ff @(posedge clk) begin
    mh_q[0] <= mask_hi;
    ml_q[0] <= mask_lo;
    for (int i = 1; i < QMD; i++) begin
      mh_q[i] <= mh_q[i-1];
      ml_q[i] <= ml_q[i-1];
    end
  end

  always_comb begin
    if (cas_lat == 2'd0)              sel = 0;
    else if (int'(cas_lat) > MAX_CL)  sel = MAX_CL - 1;
    else                              sel = int'(cas_lat) - 1;
    rd_valid = v_q[sel];
    oe_hi    = rd_valid && !mh_q[QMD-1];
    oe_lo    = rd_valid && !ml_q[QMD-1];
    rd_data  = {oe_hi ? d_q[sel][DW-1:BW] : {BW{1'b0}},
                oe_lo ? d_q[sel][BW-1:0]  : {BW{1'b0}}};
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 8,
  parameter int MAX_CL = 3,
  parameter int QMD    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_col,
  input  logic [2:0]    cfg_burst,
  input  logic [1:0]    cfg_cas_lat,
  input  logic [DW-1:0] wr_data,
  input  logic          dqm_hi,
  input  logic          dqm_lo,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          oe_hi,
  output logic          oe_lo,
  output logic          seq_violation
);
  sbs_op_e       op;
  bank_t         bank_q;
  logic          viol_q;
  logic          rw_cmd, rw_ok, stop_cmd;
  logic          acc_en, acc_wr;
  logic [AW-1:0] acc_col;
  logic [DW-1:0] arr_rdata;

  always_comb begin
    op       = sbs_op_e'(cmd_op);
    rw_cmd   = cmd_valid && (op == OP_RD || op == OP_WR);
    rw_ok    = rw_cmd && (bank_q == BANK_OPEN);
    stop_cmd = cmd_valid && (op == OP_BST || op == OP_PRE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= BANK_IDLE;
      viol_q <= 1'b0;
    end else begin
      viol_q <= rw_cmd && (bank_q != BANK_OPEN);
      if (cmd_valid) begin
        case (op)
          OP_ACT: if (bank_q == BANK_IDLE) bank_q <= BANK_OPEN;
          OP_BST: if (bank_q == BANK_OPEN) bank_q <= BANK_STOPPED;
          OP_PRE: bank_q <= BANK_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign seq_violation = viol_q;

  sbs_col_gen #(.AW(AW)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rw_ok),
    .start_wr  (op == OP_WR),
    .start_col (cmd_col),
    .bl_code   (cfg_burst),
    .stop      (stop_cmd),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_col   (acc_col)
  );

  sbs_store #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we_hi (acc_en && acc_wr && !dqm_hi),
    .we_lo (acc_en && acc_wr && !dqm_lo),
    .addr  (acc_col),
    .wdata (wr_data),
    .rdata (arr_rdata)
  );

  sbs_rd_pipe #(.DW(DW), .MAX_CL(MAX_CL), .QMD(QMD)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch      (acc_en && !acc_wr),
    .fetch_data (arr_rdata),
    .cas_lat    (cfg_cas_lat),
    .mask_hi    (dqm_hi),
    .mask_lo    (dqm_lo),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .oe_hi      (oe_hi),
    .oe_lo      (oe_lo)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
  import sbs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       dqm_hi,
  input logic       dqm_lo,
  input logic       rd_valid,
  input logic       oe_hi,
  input logic       oe_lo,
  input logic       seq_violation,
  input logic       acc_en,
  input bank_t      bank_q
);
  logic rw_in;
  assign rw_in = cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3);

  AST_OE_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && $past(dqm_hi, 2)) |-> !oe_hi); // R5
  AST_OE_HI_OPEN:   assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !$past(dqm_hi, 2)) |-> oe_hi); // R5
  AST_OE_LO_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && $past(dqm_lo, 2)) |-> !oe_lo); // R5
  AST_OE_LO_OPEN:   assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !$past(dqm_lo, 2)) |-> oe_lo); // R5
  AST_OE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (oe_hi || oe_lo) |-> rd_valid); // R5
  AST_BST_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == 3'd4) |-> !acc_en); // R2
  AST_PRE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == 3'd5) |-> !acc_en); // R11
  AST_VIOL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (rw_in && bank_q != BANK_OPEN) |=> seq_violation); // R3
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) seq_violation |-> $past(rw_in)); // R3
endmodule

bind sdram_burst_seq sbs_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .dqm_hi        (dqm_hi),
  .dqm_lo        (dqm_lo),
  .rd_valid      (rd_valid),
  .oe_hi         (oe_hi),
  .oe_lo         (oe_lo),
  .seq_violation (seq_violation),
  .acc_en        (acc_en),
  .bank_q        (bank_q)
);

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cmd_valid, dqm_hi, dqm_lo;
  logic [2:0]  cmd_op, cfg_burst;
  logic [7:0]  cmd_col;
  logic [1:0]  cfg_cas_lat;
  logic [15:0] wr_data, rd_data;
  logic        rd_valid, oe_hi, oe_lo, seq_violation;

  sdram_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_col(cmd_col), .cfg_burst(cfg_burst), .cfg_cas_lat(cfg_cas_lat),
    .wr_data(wr_data), .dqm_hi(dqm_hi), .dqm_lo(dqm_lo), .rd_data(rd_data),
    .rd_valid(rd_valid), .oe_hi(oe_hi), .oe_lo(oe_lo), .seq_violation(seq_violation)
  );

  int errs = 0, checks = 0, cyc = 0;
  string tag = "R10";
  logic [15:0] mem [256];
  bit          sv [512];
  logic [15:0] sd [512];
  bit          hh [512], hl [512];
  int          m_st = 0;
  bit          m_act = 0, m_wr = 0, m_full = 0, m_viol = 0;
  logic [7:0]  m_start = 0, m_k = 0, m_mask = 0;
  int          cl = 2;
  logic [2:0]  blc = 3'd4;

  function automatic logic [7:0] span_mask(logic [2:0] c);
    if (c == 0) return 8'h00;
    if (c == 1) return 8'h01;
    if (c == 2) return 8'h03;
    if (c == 3) return 8'h07;
    return 8'hFF;
  endfunction

  task automatic chk(string r, logic [15:0] a, logic [15:0] e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s cycle %0d: got %h expected %h", r, cyc, a, e);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic step(bit v, logic [2:0] op, logic [7:0] col, logic [15:0] wd, bit dh, bit dl);
    bit rw, acc;
    logic [7:0] ac;
    int ev_i, h_i;
    logic [15:0] ed;
    bit eh, el, ev;
    acc = 0; ac = col;
    rw = v && (op == 3'd2 || op == 3'd3);
    m_viol = rw && (m_st != 1);
    if (rw && m_st == 1) begin
      m_wr = (op == 3'd3); m_start = col; m_k = 8'd1;
      m_mask = span_mask(blc); m_full = (blc >= 3'd4);
      m_act = m_full || (m_mask != 0); acc = 1;
    end else if (v && (op == 3'd4 || op == 3'd5)) begin
      m_act = 0;
    end else if (m_act) begin
      ac = (m_start & ~m_mask) | ((m_start + m_k) & m_mask);
      acc = 1;
      if (!m_full && m_k == m_mask) m_act = 0;
      m_k = m_k + 8'd1;
    end
    if (v && op == 3'd4 && m_st == 1) m_st = 2;
    if (v && op == 3'd5) m_st = 0;
    if (v && op == 3'd1 && m_st == 0) m_st = 1;
    if (acc && m_wr) begin
      if (!dh) mem[ac][15:8] = wd[15:8];
      if (!dl) mem[ac][7:0]  = wd[7:0];
    end else if (acc) begin
      sv[(cyc + cl) % 512] = 1;
      sd[(cyc + cl) % 512] = mem[ac];
    end
    hh[cyc % 512] = dh; hl[cyc % 512] = dl;
    cmd_valid = v; cmd_op = op; cmd_col = col; wr_data = wd;
    dqm_hi = dh; dqm_lo = dl; cfg_burst = blc; cfg_cas_lat = 2'(cl);
    @(posedge clk); #1;
    cyc++;
    ev_i = cyc % 512; h_i = (cyc + 510) % 512;
    ev = sv[ev_i];
    eh = ev && !hh[h_i];
    el = ev && !hl[h_i];
    ed = {eh ? sd[ev_i][15:8] : 8'h00, el ? sd[ev_i][7:0] : 8'h00};
    chk("R4 rd_valid", 16'(rd_valid), 16'(ev));
    chk("R5 oe_hi", 16'(oe_hi), 16'(eh));
    chk("R5 oe_lo", 16'(oe_lo), 16'(el));
    chk({tag, " rd_data"}, rd_data, ed);
    chk("R3 seq_violation", 16'(seq_violation), 16'(m_viol));
    sv[ev_i] = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 3'd0, 8'd0, 16'd0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    for (int i = 0; i < 512; i++) begin sv[i] = 0; hh[i] = 0; hl[i] = 0; sd[i] = 0; end
    void'($urandom(32'h5EED1234));
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_col = 0; wr_data = 0;
    dqm_hi = 0; dqm_lo = 0; cfg_burst = 3'd4; cfg_cas_lat = 2'd2;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    // R10: reset state
    chk("R10 rd_valid", 16'(rd_valid), 16'd0);
    chk("R10 rd_data", rd_data, 16'd0);
    chk("R10 oe", 16'({oe_hi, oe_lo}), 16'd0);
    chk("R10 seq_violation", 16'(seq_violation), 16'd0);
    tag = "R10"; step(1, 3'd2, 8'h00, 16'd0, 0, 0);   // read while closed

    // R1: full-page write wraps past 256 columns
    tag = "R1"; blc = 3'd4;
    step(1, 3'd1, 8'h00, 16'd0, 0, 0);
    step(1, 3'd3, 8'hF0, 16'h1000, 0, 0);
    for (int i = 1; i < 300; i++) step(0, 3'd0, 8'h00, 16'h1000 + 16'(i), 0, 0);
    tag = "R2"; step(1, 3'd4, 8'h00, 16'hDEAD, 0, 0);  // not stored
    step(0, 3'd0, 8'h00, 16'hBEEF, 0, 0);
    tag = "R3"; step(1, 3'd3, 8'h10, 16'h5555, 0, 0);  // stopped bank
    step(1, 3'd1, 8'h00, 16'd0, 0, 0);                 // open ignored while stopped
    step(1, 3'd2, 8'h10, 16'd0, 0, 0);
    step(1, 3'd5, 8'h00, 16'd0, 0, 0);
    step(1, 3'd1, 8'h00, 16'd0, 0, 0);
    tag = "R1,R2"; step(1, 3'd2, 8'hF0, 16'd0, 0, 0);
    for (int i = 1; i < 300; i++) step(0, 3'd0, 8'h00, 16'd0, 0, 0);
    step(1, 3'd4, 8'h00, 16'd0, 0, 0);
    idle(4);
    step(1, 3'd5, 8'h00, 16'd0, 0, 0);
    step(1, 3'd1, 8'h00, 16'd0, 0, 0);

    // R7: short bursts wrap in aligned blocks
    tag = "R7";
    for (int b = 0; b < 4; b++) begin
      blc = 3'(b);
      step(1, 3'd3, 8'h23 + 8'(b * 16), 16'hA000 + 16'(b * 16), 0, 0);
      for (int i = 1; i < 8; i++) step(0, 3'd0, 8'h00, 16'hA000 + 16'(b * 16 + i), 0, 0);
    end
    for (int c = 1; c <= 3; c++) begin
      idle(4); cl = c;
      for (int b = 0; b < 4; b++) begin
        blc = 3'(b);
        step(1, 3'd2, 8'h23 + 8'(b * 16), 16'd0, 0, 0);
        idle(9);
      end
    end
    idle(4); cl = 2;

    // R8: new read truncates a full-page burst
    tag = "R8"; blc = 3'd4;
    step(1, 3'd2, 8'h40, 16'd0, 0, 0);
    idle(5);
    step(1, 3'd2, 8'h80, 16'd0, 0, 0);
    idle(5);
    blc = 3'd2;
    step(1, 3'd3, 8'h81, 16'h7777, 0, 0);
    step(1, 3'd3, 8'h90, 16'h8888, 0, 0);
    idle(5);
    step(1, 3'd4, 8'h00, 16'd0, 0, 0);
    step(1, 3'd5, 8'h00, 16'd0, 0, 0);
    step(1, 3'd1, 8'h00, 16'd0, 0, 0);

    // R5/R6: read masking, counter keeps moving
    tag = "R6"; blc = 3'd3;
    step(1, 3'd2, 8'h60, 16'd0, 1, 0);
    step(0, 3'd0, 8'h00, 16'd0, 1, 1);
    step(0, 3'd0, 8'h00, 16'd0, 0, 1);
    step(0, 3'd0, 8'h00, 16'd0, 0, 0);
    step(0, 3'd0, 8'h00, 16'd0, 1, 0);
    idle(6);

    // R9: write byte masks, then read back
    tag = "R9"; blc = 3'd2;
    step(1, 3'd3, 8'h64, 16'hC1C2, 1, 0);
    step(0, 3'd0, 8'h00, 16'hC3C4, 0, 1);
    step(0, 3'd0, 8'h00, 16'hC5C6, 1, 1);
    step(0, 3'd0, 8'h00, 16'hC7C8, 0, 0);
    step(1, 3'd2, 8'h64, 16'd0, 0, 0);
    idle(6);

    // R11: close ends a write burst
    tag = "R11"; blc = 3'd4;
    step(1, 3'd3, 8'hA0, 16'hE000, 0, 0);
    step(0, 3'd0, 8'h00, 16'hE001, 0, 0);
    step(1, 3'd5, 8'h00, 16'hE002, 0, 0);
    step(0, 3'd0, 8'h00, 16'hE003, 0, 0);
    step(1, 3'd1, 8'h00, 16'd0, 0, 0);
    step(1, 3'd2, 8'hA0, 16'd0, 0, 0);
    idle(5);
    step(1, 3'd4, 8'h00, 16'd0, 0, 0);
    idle(4);

    // Random mix
    tag = "R4";
    for (int seg = 0; seg < 6; seg++) begin
      idle(4);
      cl = 1 + int'($urandom % 3);
      for (int i = 0; i < 700; i++) begin
        int r;
        logic [2:0] op;
        r = int'($urandom % 100);
        if (r < 6) op = 3'd1;
        else if (r < 10) op = 3'd5;
        else if (r < 14) op = 3'd4;
        else if (r < 24) op = 3'd2;
        else if (r < 34) op = 3'd3;
        else op = 3'd0;
        blc = 3'($urandom % 5);
        step(op != 3'd0, op, 8'($urandom), 16'($urandom),
             ($urandom % 4) == 0, ($urandom % 4) == 0);
      end
    end
    idle(6);
    summary();
  end
endmodule